// File: doc/BRIEF.md
# Crystal Oscillator Controller with Startup Timer and Clock Divider

This block is the digital side of an external crystal oscillator. A power enable from the mode controller switches the oscillator driver on and off. Each time the oscillator goes from off to on, a startup timer runs. The timer counts a programmable number of oscillator clock cycles, and only then does the block report that a usable clock is available. In bypass mode an external clock is fed straight through. The driver then stays off, the timer is skipped, and the clock counts as available one cycle after the enable.

The rising edge of clock-available sets a sticky event flag. Software clears the flag by writing 1 to it, and the flag drives the interrupt line only when its enable bit is set. While the clock is available, the block sends the oscillator clock out divided by any integer from 1 to 32. A new factor takes effect only at the end of the current output period, so no runt pulse appears. The whole block, register bus included, runs on the oscillator clock.

Register map (2-bit word address, 32-bit data): address 0 is the control word. Address 1 holds the startup cycle count. Address 2 is the status word. Address 3 reads as zero.

Top module: `xosc_ctrl`

## Requirements
- R1: After reset, `osc_drv_en`, `clk_avail`, `irq` and `clk_div_o` are 0. The control word (address 0) reads 0 and the startup count (address 1) reads the parameter `STARTUP_RST`.
- R2: `osc_drv_en` is 1 exactly when `pwr_en` is 1 and the bypass bit (control bit 0) is 0.
- R3: With bypass off and startup count T in address 1 bits [CNT_W-1:0], `clk_avail` goes high at the (T+1)-th rising edge at which `pwr_en` is sampled high.
- R4: A rising edge that samples `pwr_en` low clears `clk_avail` and the startup timer. The next off-to-on transition then needs the full T+1 edges again.
- R5: With bypass on, `clk_avail` goes high at the first rising edge that samples `pwr_en` high.
- R6: The rise of `clk_avail` sets the event flag (status bit 1). Status bit 0 reads `clk_avail`. Writing 1 to status bit 1 clears the flag and writing 0 leaves it unchanged. If the flag is set and cleared at the same edge, the set wins.
- R7: `irq` equals the event flag ANDed with the interrupt enable (control bit 1).
- R8: The divide factor is F = control bits [12:8] + 1. For F ≥ 2, `clk_div_o` is a registered output. Each period is F input cycles long, starts high, stays high for floor(F/2) cycles and is then low.
- R9: For F = 1, `clk_div_o` follows the oscillator clock while `clk_avail` is high.
- R10: A new factor takes effect only after the current output period has ended. While `clk_avail` is low, `clk_div_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Raw oscillator clock; clocks the whole block |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_en | input | 1 | Oscillator power enable from the mode controller |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational on bus_addr) |
| osc_drv_en | output | 1 | Enable for the analog oscillator driver |
| clk_div_o | output | 1 | Divided output clock |
| clk_avail | output | 1 | Oscillator clock valid and stable |
| irq | output | 1 | Clock-available interrupt |

## Verification
The startup timer can reach its terminal count at the same edge at which software writes 1 to clear the event flag. The bench provokes this by starting a short startup and holding the clearing write high on exactly the (T+1)-th edge. It then expects the flag to read 1, because the set takes priority, and confirms that a later write does clear the flag. A factor change can also land in the middle of a divided period. The bench rewrites the factor one cycle after a period starts and expects the remainder of that period in the old shape and the following period in the new shape.

// File: rtl/xosc_pkg.sv
package xosc_pkg;
   localparam int unsigned XOSC_DIV_W   = 5;
   localparam int unsigned XOSC_DIV_LSB = 8;

   typedef enum logic [1:0] {
      RA_CTRL   = 2'd0,
      RA_SUTIME = 2'd1,
      RA_STAT   = 2'd2,
      RA_NONE   = 2'd3
   } xosc_addr_e;

   typedef struct packed {
      logic                  bypass;
      logic                  irq_en;
      logic [XOSC_DIV_W-1:0] div_m1;
   } xosc_cfg_t;
endpackage

// File: rtl/xosc_startup.sv
module xosc_startup #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk_osc,
   input  logic             rst_n,
   input  logic             pwr_en,
   input  logic             bypass,
   input  logic [CNT_W-1:0] term,
   output logic             avail,
   output logic             avail_set
);
   logic [CNT_W-1:0] cnt;

   assign avail_set = pwr_en && !avail && (bypass || (cnt == term));

   always_ff @(posedge clk_osc or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         avail <= 1'b0;
      end else if (!pwr_en) begin
         cnt   <= '0;
         avail <= 1'b0;
      end else if (avail_set) begin
         avail <= 1'b1;
      end else if (!avail) begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/xosc_clkdiv.sv
module xosc_clkdiv #(
   parameter int unsigned DIV_W = 5
) (
   input  logic             clk_osc,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] req_m1,
   output logic             clk_out,
   output logic [DIV_W-1:0] fac_m1,
   output logic             period_end
);
   logic [DIV_W-1:0] dcnt;
   logic [DIV_W:0]   hi_len;
   logic [DIV_W:0]   nxt;
   logic             div_q;
   logic             gate_en;

   assign period_end = (dcnt == fac_m1);
   assign hi_len     = ({1'b0, fac_m1} + 1'b1) >> 1;
   assign nxt        = {1'b0, dcnt} + 1'b1;

   always_ff @(posedge clk_osc or negedge rst_n) begin
      if (!rst_n) begin
         dcnt   <= '0;
         fac_m1 <= '0;
         div_q  <= 1'b0;
      end else if (!run) begin
         // park on the terminal count so the first running edge opens a period
         dcnt   <= req_m1;
         fac_m1 <= req_m1;
         div_q  <= 1'b0;
      end else if (period_end) begin
         dcnt   <= '0;
         fac_m1 <= req_m1;
         div_q  <= (req_m1 != '0);
      end else begin
         dcnt  <= dcnt + 1'b1;
         div_q <= (nxt < hi_len);
      end
   end

   // divide-by-one path: enable changes only while the clock is low
   always_ff @(negedge clk_osc or negedge rst_n) begin
      if (!rst_n) gate_en <= 1'b0;
      else        gate_en <= run && (fac_m1 == '0);
   end

   assign clk_out = (clk_osc & gate_en) | div_q;
endmodule

// File: rtl/xosc_regs.sv
module xosc_regs
   import xosc_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned STARTUP_RST = 255,
   parameter int unsigned MAX_DIV     = 32,
   parameter bit          HAS_BYPASS  = 1'b1
) (
   input  logic             clk_osc,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic [1:0]       bus_addr,
   input  logic [31:0]      bus_wdata,
   output logic [31:0]      bus_rdata,
   input  logic             avail,
   input  logic             avail_set,
   output xosc_cfg_t        cfg,
   output logic [CNT_W-1:0] term,
   output logic             flag
);
   localparam logic [XOSC_DIV_W-1:0] TOP_M1 = XOSC_DIV_W'(MAX_DIV - 1);

   logic                  wr_ctrl, wr_sut, wr_stat;
   logic [XOSC_DIV_W-1:0] wr_m1;
   logic                  irq_en_q;
   logic [XOSC_DIV_W-1:0] div_m1_q;
   logic                  unused_wdata;

   assign wr_ctrl = bus_wr && (bus_addr == RA_CTRL);
   assign wr_sut  = bus_wr && (bus_addr == RA_SUTIME);
   assign wr_stat = bus_wr && (bus_addr == RA_STAT);
   assign wr_m1   = bus_wdata[XOSC_DIV_LSB +: XOSC_DIV_W];
   assign unused_wdata = ^bus_wdata;

   always_ff @(posedge clk_osc or negedge rst_n) begin
      if (!rst_n) begin
         irq_en_q <= 1'b0;
         div_m1_q <= '0;
         term     <= CNT_W'(STARTUP_RST);
      end else begin
         if (wr_ctrl) begin
            irq_en_q <= bus_wdata[1];
            div_m1_q <= (wr_m1 > TOP_M1) ? TOP_M1 : wr_m1;
         end
         if (wr_sut) term <= bus_wdata[CNT_W-1:0];
      end
   end

   // set has priority over a same-edge write-one-to-clear
   always_ff @(posedge clk_osc or negedge rst_n) begin
      if (!rst_n)                     flag <= 1'b0;
      else if (avail_set)             flag <= 1'b1;
      else if (wr_stat && bus_wdata[1]) flag <= 1'b0;
   end

   generate
      if (HAS_BYPASS) begin : g_byp
         logic byp_q;
         always_ff @(posedge clk_osc or negedge rst_n) begin
            if (!rst_n)       byp_q <= 1'b0;
            else if (wr_ctrl) byp_q <= bus_wdata[0];
         end
         assign cfg.bypass = byp_q;
      end else begin : g_nobyp
         assign cfg.bypass = 1'b0;
      end
   endgenerate

   assign cfg.irq_en = irq_en_q;
   assign cfg.div_m1 = div_m1_q;

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         RA_CTRL: begin
            bus_rdata[0] = cfg.bypass;
            bus_rdata[1] = cfg.irq_en;
            bus_rdata[XOSC_DIV_LSB +: XOSC_DIV_W] = cfg.div_m1;
         end
         RA_SUTIME: bus_rdata[CNT_W-1:0] = term;
         RA_STAT: begin
            bus_rdata[0] = avail;
            bus_rdata[1] = flag;
         end
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/xosc_ctrl.sv
module xosc_ctrl
   import xosc_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned STARTUP_RST = 255,
   parameter int unsigned MAX_DIV     = 32,
   parameter bit          HAS_BYPASS  = 1'b1
) (
   input  logic        clk_osc,
   input  logic        rst_n,
   input  logic        pwr_en,
   input  logic        bus_wr,
   input  logic [1:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        osc_drv_en,
   output logic        clk_div_o,
   output logic        clk_avail,
   output logic        irq
);
   localparam int unsigned DIV_W = XOSC_DIV_W;

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
         $error("xosc_ctrl: CNT_W must lie in 2..32");
      end
      if (MAX_DIV < 1 || MAX_DIV > (1 << DIV_W)) begin : g_bad_div
         $error("xosc_ctrl: MAX_DIV must lie in 1..2**DIV_W");
      end
      if (longint'(STARTUP_RST) >= (longint'(1) << CNT_W)) begin : g_bad_rst
         $error("xosc_ctrl: STARTUP_RST does not fit CNT_W");
      end
   endgenerate

   xosc_cfg_t        cfg;
   logic [CNT_W-1:0] term;
   logic             irq_flag;
   logic             avail_set;
   logic [DIV_W-1:0] fac_m1;
   logic             period_end;

   xosc_regs #(
      .CNT_W(CNT_W), .STARTUP_RST(STARTUP_RST),
      .MAX_DIV(MAX_DIV), .HAS_BYPASS(HAS_BYPASS)
   ) u_regs (
      .clk_osc(clk_osc), .rst_n(rst_n),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .avail(clk_avail), .avail_set(avail_set),
      .cfg(cfg), .term(term), .flag(irq_flag)
   );

   xosc_startup #(.CNT_W(CNT_W)) u_start (
      .clk_osc(clk_osc), .rst_n(rst_n), .pwr_en(pwr_en),
      .bypass(cfg.bypass), .term(term),
      .avail(clk_avail), .avail_set(avail_set)
   );

   xosc_clkdiv #(.DIV_W(DIV_W)) u_div (
      .clk_osc(clk_osc), .rst_n(rst_n), .run(clk_avail),
      .req_m1(cfg.div_m1), .clk_out(clk_div_o),
      .fac_m1(fac_m1), .period_end(period_end)
   );

   assign osc_drv_en = pwr_en & ~cfg.bypass;
   assign irq        = irq_flag & cfg.irq_en;
endmodule

// File: rtl/xosc_ctrl_chk.sv
module xosc_ctrl_chk #(
   parameter int unsigned DIV_W = 5
) (
   input logic             clk_osc,
   input logic             rst_n,
   input logic             pwr_en,
   input logic             osc_drv_en,
   input logic             clk_avail,
   input logic             irq,
   input logic             irq_flag,
   input logic [DIV_W-1:0] fac_m1,
   input logic             period_end
);
   AST_DRV_NEEDS_EN: assert property (@(posedge clk_osc) disable iff (!rst_n)
      osc_drv_en |-> pwr_en); // R2

   AST_OFF_CLEARS: assert property (@(posedge clk_osc) disable iff (!rst_n)
      !pwr_en |=> !clk_avail); // R4

   AST_AVAIL_NEEDS_EN: assert property (@(posedge clk_osc) disable iff (!rst_n)
      $rose(clk_avail) |-> $past(pwr_en)); // R3

   AST_FLAG_ON_RISE: assert property (@(posedge clk_osc) disable iff (!rst_n)
      $rose(clk_avail) |-> irq_flag); // R6

   AST_IRQ_GATED: assert property (@(posedge clk_osc) disable iff (!rst_n)
      irq |-> irq_flag); // R7

   AST_DIV_SWITCH: assert property (@(posedge clk_osc) disable iff (!rst_n)
      !$stable(fac_m1) |-> ($past(period_end) || !$past(clk_avail))); // R10
endmodule

bind xosc_ctrl xosc_ctrl_chk #(.DIV_W(DIV_W)) u_chk (
   .clk_osc(clk_osc), .rst_n(rst_n), .pwr_en(pwr_en),
   .osc_drv_en(osc_drv_en), .clk_avail(clk_avail), .irq(irq),
   .irq_flag(irq_flag), .fac_m1(fac_m1), .period_end(period_end)
);

// File: tb/sim_xosc_ctrl.sv
`timescale 1ns/1ps
module sim_xosc_ctrl;
   localparam int unsigned SU_RST = 200;

   logic        clk_osc = 1'b0;
   logic        rst_n = 1'b0;
   logic        pwr_en = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        osc_drv_en, clk_div_o, clk_avail, irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk_osc = ~clk_osc;

   xosc_ctrl #(.STARTUP_RST(SU_RST)) u0 (
      .clk_osc(clk_osc), .rst_n(rst_n), .pwr_en(pwr_en),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .osc_drv_en(osc_drv_en),
      .clk_div_o(clk_div_o), .clk_avail(clk_avail), .irq(irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk_osc);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk_osc);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk_osc);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic startup_len(output int n);
      n = 0;
      do begin
         @(posedge clk_osc); #1;
         n++;
      end while (!clk_avail && n < 5000);
   endtask

   task automatic power_off();
      @(negedge clk_osc); pwr_en = 1'b0;
      repeat (2) @(posedge clk_osc);
   endtask

   task automatic wait_rise();
      logic prev;
      @(posedge clk_osc); #1 prev = clk_div_o;
      for (int k = 0; k < 200; k++) begin
         @(posedge clk_osc); #1;
         if (!prev && clk_div_o) break;
         prev = clk_div_o;
      end
   endtask

   task automatic measure(output int h, output int l);
      wait_rise();
      h = 1; l = 0;
      for (int k = 0; k < 100; k++) begin
         @(posedge clk_osc); #1;
         if (clk_div_o) h++; else break;
      end
      l = 1;
      for (int k = 0; k < 100; k++) begin
         @(posedge clk_osc); #1;
         if (!clk_div_o) l++; else break;
      end
   endtask

   initial begin
      #(4 * 190000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int n, h, l;
      logic s [0:12];

      repeat (3) @(negedge clk_osc);
      rst_n = 1'b1;
      @(negedge clk_osc); #1;
      // R1 reset state
      chk("R1 drv", osc_drv_en, 0);
      chk("R1 avail", clk_avail, 0);
      chk("R1 irq", irq, 0);
      chk("R1 divout", clk_div_o, 0);
      rd(2'd0, d); chk("R1 ctrl", d, 0);
      rd(2'd1, d); chk("R1 sutime", d, SU_RST);

      // R3 startup length sweep, R2 driver on, R4 off clears
      foreach (n_list[i]) begin end
      for (int t = 0; t < 24; t += 3) begin
         wr(2'd1, t);
         @(negedge clk_osc); pwr_en = 1'b1;
         #1 chk("R2 drv on", osc_drv_en, 1);
         startup_len(n);
         chk($sformatf("R3 startup T=%0d", t), n, t + 1);
         @(negedge clk_osc); pwr_en = 1'b0;
         @(posedge clk_osc); #1 chk("R4 off clears", clk_avail, 0);
         #1 chk("R2 drv off", osc_drv_en, 0);
         wr(2'd2, 32'h2);
      end

      // R4 restart after a short drop
      wr(2'd1, 10);
      @(negedge clk_osc); pwr_en = 1'b1;
      repeat (6) @(posedge clk_osc);
      @(negedge clk_osc); pwr_en = 1'b0;
      @(negedge clk_osc); pwr_en = 1'b1;
      startup_len(n);
      chk("R4 restart full count", n, 11);

      // R6 flag, R7 irq gating
      rd(2'd2, d); chk("R6 status after rise", d, 3);
      chk("R7 irq masked", irq, 0);
      wr(2'd2, 32'h0);
      rd(2'd2, d); chk("R6 write0 keeps flag", d[1], 1);
      wr(2'd0, 32'h2);
      #1 chk("R7 irq enabled", irq, 1);
      wr(2'd2, 32'h2);
      #1 chk("R7 irq after clear", irq, 0);
      rd(2'd2, d); chk("R6 w1c clears", d[1], 0);

      // R6 set and clear at the same edge
      power_off();
      wr(2'd1, 3);
      @(negedge clk_osc); pwr_en = 1'b1;
      repeat (3) @(posedge clk_osc);
      @(negedge clk_osc);
      bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 32'h2;
      @(negedge clk_osc); bus_wr = 1'b0;
      rd(2'd2, d); chk("R6 set beats clear", d, 3);
      wr(2'd2, 32'h2);
      rd(2'd2, d); chk("R6 later clear", d, 1);

      // R5 bypass
      power_off();
      wr(2'd0, 32'h1);
      @(negedge clk_osc); pwr_en = 1'b1;
      #1 chk("R2 drv off in bypass", osc_drv_en, 0);
      startup_len(n);
      chk("R5 bypass startup", n, 1);

      // R8 divider sweep F=2..32
      for (int f = 2; f <= 32; f++) begin
         wr(2'd0, 32'h1 | ((f - 1) << 8));
         repeat (70) @(posedge clk_osc);
         measure(h, l);
         chk($sformatf("R8 high F=%0d", f), h, f / 2);
         chk($sformatf("R8 low F=%0d", f), l, f - f / 2);
      end

      // R9 divide by one
      wr(2'd0, 32'h1);
      repeat (70) @(posedge clk_osc);
      for (int k = 0; k < 4; k++) begin
         @(posedge clk_osc); #1 chk("R9 follows high", clk_div_o, 1);
         @(negedge clk_osc); #1 chk("R9 follows low", clk_div_o, 0);
      end
      power_off();
      for (int k = 0; k < 3; k++) begin
         @(posedge clk_osc); #1 chk("R10 idle high phase", clk_div_o, 0);
         @(negedge clk_osc); #1 chk("R10 idle low phase", clk_div_o, 0);
      end

      // R10 factor change mid-period: 8 -> 4
      wr(2'd0, 32'h1 | (7 << 8));
      @(negedge clk_osc); pwr_en = 1'b1;
      repeat (70) @(posedge clk_osc);
      wait_rise();
      s[0] = clk_div_o;
      @(negedge clk_osc);
      bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 32'h1 | (3 << 8);
      @(posedge clk_osc); #1 s[1] = clk_div_o;
      @(negedge clk_osc); bus_wr = 1'b0;
      for (int i = 2; i <= 12; i++) begin
         @(posedge clk_osc); #1 s[i] = clk_div_o;
      end
      for (int i = 0; i <= 12; i++) begin
         int e;
         e = (i < 4) ? 1 : (i < 8) ? 0 : (i < 10) ? 1 : (i < 12) ? 0 : 1;
         chk($sformatf("R10 boundary cycle %0d", i), s[i], e);
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   int n_list [1];
endmodule